// File: doc/BRIEF.md
# DDR2 Bank Timing Guard

This block sits between the command scheduler of a DDR2 memory controller and the physical layer. It keeps the state of all eight banks of one DDR2 device: whether a row is open, and how many clock cycles remain before each timing window closes. Each cycle the scheduler presents at most one request, made of a command code and a bank number. The guard answers in the same cycle. A grant means the command may go to the pins in this cycle. The illegal flag means the command can never be legal in the bank's present state. When neither is set, the scheduler keeps the request in place until it is granted.

All timing limits are clock-cycle counts. They are loaded from parameter defaults at reset and can be replaced through a configuration write. The same write also sets the CAS latency and the additive latency. From these two values the block derives a read latency (additive plus CAS) and a write latency one cycle shorter. The controller's data path uses both latencies.

Top module: `ddr2_bank_guard`

## Requirements
- R1: Every bank has its own open-row state and timers. An ACTIVATE to a closed, rested bank is granted in the first cycle it is presented, whatever the other banks are doing. After a granted ACTIVATE, that bank reads as open.
- R2: A READ (code 2) or WRITE (code 3) to an open bank is granted no earlier than the row-to-column delay, counted in cycles after that bank's ACTIVATE.
- R3: A PRECHARGE (code 4) to an open bank is granted no earlier than the row-active time, counted in cycles after that bank's ACTIVATE. The grant closes the bank.
- R4: An ACTIVATE (code 1) to a bank waits until both limits have passed: the precharge time after that bank's last closing, and the row-cycle time after its previous ACTIVATE.
- R5: PRECHARGE-ALL (code 5) is granted only when every open bank has met its row-active time. It closes all banks, and afterwards no bank may be activated until the precharge-all period has passed.
- R6: A READ or WRITE to a closed bank, an ACTIVATE to an open bank, and the unused codes 6 and 7 raise the illegal flag and are never granted. NOP (code 0) raises neither grant nor the illegal flag.
- R7: The read latency output equals the CAS latency plus the additive latency. The write latency output is always one less than the read latency.
- R8: A configuration write is taken only in a cycle where all banks are closed and no command is granted. A CAS latency outside 3..7 or an additive latency above 6 causes the write to be rejected. Timing counts that are taken apply to later commands.
- R9: Grant is only ever raised while a request is valid, and never together with the illegal flag. At most one command is granted per cycle.
- R10: After reset all banks are closed, no timer is running, and the latencies come from the defaults (CAS 5, additive 0, so read 5 and write 4).
- R11: A PRECHARGE to a bank that is already closed is granted at once as a no-op. It does not restart that bank's precharge time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE-ALL |
| req_bank | input | 3 | Target bank |
| grant | output | 1 | The request is legal in this cycle and is taken |
| illegal | output | 1 | The request can never be legal in the present bank state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_trcd | input | 6 | Row-to-column delay in cycles |
| cfg_trp | input | 6 | Single-bank precharge time in cycles |
| cfg_tras | input | 6 | Row-active time in cycles |
| cfg_trc | input | 6 | Row-cycle time in cycles |
| cfg_tprea | input | 6 | Precharge-all period in cycles |
| cfg_cl | input | 3 | CAS latency |
| cfg_al | input | 3 | Additive latency |
| rd_lat | output | 4 | Read latency in cycles |
| wr_lat | output | 4 | Write latency in cycles |

## Verification
The assertions assume three things about the inputs. A held request keeps the same command and bank until it is granted or flagged. Reset is applied before the first command. Configuration writes arrive only while no request is being granted. Under these assumptions, each per-bank elapsed-cycle counter in the checker is a true measure of time since that bank's ACTIVATE. The stimulus meets all three. It drives one request at a time and drops it in the cycle after the grant or the flag. It issues configuration writes only while the request line is idle. It holds reset for several cycles before any command.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
  localparam int CMD_W  = 3;
  localparam int MIN_CL = 3;
  localparam int MAX_AL = 6;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5
  } guard_cmd_e;
endpackage

// File: rtl/ddr2_guard_cfg.sv
module ddr2_guard_cfg
  import ddr2_guard_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int LAT_W     = 4,
  parameter int DEF_TRCD  = 5,
  parameter int DEF_TRP   = 5,
  parameter int DEF_TRAS  = 18,
  parameter int DEF_TRC   = 23,
  parameter int DEF_TPREA = 7,
  parameter int DEF_CL    = 5,
  parameter int DEF_AL    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             banks_idle,
  input  logic             cmd_granted,
  input  logic [CNT_W-1:0] in_trcd,
  input  logic [CNT_W-1:0] in_trp,
  input  logic [CNT_W-1:0] in_tras,
  input  logic [CNT_W-1:0] in_trc,
  input  logic [CNT_W-1:0] in_tprea,
  input  logic [2:0]       in_cl,
  input  logic [2:0]       in_al,
  output logic [CNT_W-1:0] t_rcd,
  output logic [CNT_W-1:0] t_rp,
  output logic [CNT_W-1:0] t_ras,
  output logic [CNT_W-1:0] t_rc,
  output logic [CNT_W-1:0] t_prea,
  output logic [LAT_W-1:0] rd_lat,
  output logic [LAT_W-1:0] wr_lat
);
  localparam logic [LAT_W-1:0] DEF_RD = LAT_W'(DEF_CL + DEF_AL);

  logic             cl_ok, al_ok, take;
  logic [LAT_W-1:0] new_rd;

  // CAS latency range 3..7 (upper bound is the field maximum), additive 0..6
  assign cl_ok  = (in_cl >= 3'(MIN_CL));
  assign al_ok  = (in_al <= 3'(MAX_AL));
  assign take   = wr_req && banks_idle && !cmd_granted && cl_ok && al_ok;
  assign new_rd = LAT_W'(in_cl) + LAT_W'(in_al);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_rcd  <= CNT_W'(DEF_TRCD);
      t_rp   <= CNT_W'(DEF_TRP);
      t_ras  <= CNT_W'(DEF_TRAS);
      t_rc   <= CNT_W'(DEF_TRC);
      t_prea <= CNT_W'(DEF_TPREA);
      rd_lat <= DEF_RD;
      wr_lat <= DEF_RD - LAT_W'(1);
    end else if (take) begin
      t_rcd  <= in_trcd;
      t_rp   <= in_trp;
      t_ras  <= in_tras;
      t_rc   <= in_trc;
      t_prea <= in_tprea;
      rd_lat <= new_rd;
      wr_lat <= new_rd - LAT_W'(1);
    end
  end
endmodule

// File: rtl/ddr2_guard_bank.sv
module ddr2_guard_bank #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_go,
  input  logic             close_go,
  input  logic             prea_go,
  input  logic [CNT_W-1:0] t_rcd,
  input  logic [CNT_W-1:0] t_rp,
  input  logic [CNT_W-1:0] t_ras,
  input  logic [CNT_W-1:0] t_rc,
  input  logic [CNT_W-1:0] t_prea,
  output logic             is_open,
  output logic             act_rdy,
  output logic             rw_rdy,
  output logic             pre_rdy
);
  logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q;
  logic [CNT_W-1:0] rcd_d, ras_d, rc_d, rp_d;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  // a limit of T cycles lets the next command go T cycles after this one
  function automatic logic [CNT_W-1:0] arm(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] larger(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    rcd_d = act_go ? arm(t_rcd) : step(rcd_q);
    ras_d = act_go ? arm(t_ras) : step(ras_q);
    rc_d  = act_go ? arm(t_rc)  : step(rc_q);
    if (prea_go)
      rp_d = larger(step(rp_q), arm(t_prea));
    else if (close_go)
      rp_d = larger(step(rp_q), arm(t_rp));
    else
      rp_d = step(rp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcd_q   <= '0;
      ras_q   <= '0;
      rc_q    <= '0;
      rp_q    <= '0;
      is_open <= 1'b0;
      act_rdy <= 1'b1;
      rw_rdy  <= 1'b1;
      pre_rdy <= 1'b1;
    end else begin
      rcd_q   <= rcd_d;
      ras_q   <= ras_d;
      rc_q    <= rc_d;
      rp_q    <= rp_d;
      if (act_go)
        is_open <= 1'b1;
      else if (close_go || prea_go)
        is_open <= 1'b0;
      act_rdy <= (rc_d == '0) && (rp_d == '0);
      rw_rdy  <= (rcd_d == '0);
      pre_rdy <= (ras_d == '0);
    end
  end
endmodule

// File: rtl/ddr2_guard_decode.sv
module ddr2_guard_decode
  import ddr2_guard_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int BANK_W = 3
) (
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [N_BANK-1:0] open_vec,
  input  logic [N_BANK-1:0] act_rdy_vec,
  input  logic [N_BANK-1:0] rw_rdy_vec,
  input  logic [N_BANK-1:0] pre_rdy_vec,
  output logic              grant,
  output logic              illegal,
  output logic [N_BANK-1:0] act_go,
  output logic [N_BANK-1:0] close_go,
  output logic              prea_go
);
  logic sel_open, sel_act, sel_rw, sel_pre, all_pre_ok;

  assign sel_open   = open_vec[req_bank];
  assign sel_act    = act_rdy_vec[req_bank];
  assign sel_rw     = rw_rdy_vec[req_bank];
  assign sel_pre    = pre_rdy_vec[req_bank];
  assign all_pre_ok = &(~open_vec | pre_rdy_vec);

  always_comb begin
    grant   = 1'b0;
    illegal = 1'b0;
    if (req_valid) begin
      case (req_cmd)
        CMD_NOP: ;
        CMD_ACT: begin
          if (sel_open) illegal = 1'b1;
          else          grant   = sel_act;
        end
        CMD_RD, CMD_WR: begin
          if (!sel_open) illegal = 1'b1;
          else           grant   = sel_rw;
        end
        CMD_PRE:  grant   = !sel_open || sel_pre;
        CMD_PREA: grant   = all_pre_ok;
        default:  illegal = 1'b1;
      endcase
    end
  end

  assign prea_go = grant && (req_cmd == CMD_PREA);

  for (genvar b = 0; b < N_BANK; b++) begin : g_go
    assign act_go[b]   = grant && (req_cmd == CMD_ACT) && (req_bank == BANK_W'(b));
    assign close_go[b] = grant && (req_cmd == CMD_PRE) && (req_bank == BANK_W'(b))
                         && open_vec[b];
  end
endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
  import ddr2_guard_pkg::*;
#(
  parameter int N_BANK    = 8,
  parameter int CNT_W     = 6,
  parameter int LAT_W     = 4,
  parameter int DEF_TRCD  = 5,
  parameter int DEF_TRP   = 5,
  parameter int DEF_TRAS  = 18,
  parameter int DEF_TRC   = 23,
  parameter int DEF_TPREA = 7,
  parameter int DEF_CL    = 5,
  parameter int DEF_AL    = 0,
  localparam int BANK_W   = $clog2(N_BANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  output logic              grant,
  output logic              illegal,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_trcd,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_tras,
  input  logic [CNT_W-1:0]  cfg_trc,
  input  logic [CNT_W-1:0]  cfg_tprea,
  input  logic [2:0]        cfg_cl,
  input  logic [2:0]        cfg_al,
  output logic [LAT_W-1:0]  rd_lat,
  output logic [LAT_W-1:0]  wr_lat
);
  logic [CNT_W-1:0]  t_rcd, t_rp, t_ras, t_rc, t_prea;
  logic [N_BANK-1:0] open_vec, act_rdy_vec, rw_rdy_vec, pre_rdy_vec;
  logic [N_BANK-1:0] act_go, close_go;
  logic              prea_go;

  ddr2_guard_cfg #(
    .CNT_W(CNT_W), .LAT_W(LAT_W),
    .DEF_TRCD(DEF_TRCD), .DEF_TRP(DEF_TRP), .DEF_TRAS(DEF_TRAS),
    .DEF_TRC(DEF_TRC), .DEF_TPREA(DEF_TPREA),
    .DEF_CL(DEF_CL), .DEF_AL(DEF_AL)
  ) i_cfg (
    .clk(clk), .rst(rst),
    .wr_req(cfg_we), .banks_idle(~|open_vec), .cmd_granted(grant),
    .in_trcd(cfg_trcd), .in_trp(cfg_trp), .in_tras(cfg_tras),
    .in_trc(cfg_trc), .in_tprea(cfg_tprea), .in_cl(cfg_cl), .in_al(cfg_al),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc), .t_prea(t_prea),
    .rd_lat(rd_lat), .wr_lat(wr_lat)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    ddr2_guard_bank #(.CNT_W(CNT_W)) i_bank (
      .clk(clk), .rst(rst),
      .act_go(act_go[b]), .close_go(close_go[b]), .prea_go(prea_go),
      .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc), .t_prea(t_prea),
      .is_open(open_vec[b]), .act_rdy(act_rdy_vec[b]),
      .rw_rdy(rw_rdy_vec[b]), .pre_rdy(pre_rdy_vec[b])
    );
  end

  ddr2_guard_decode #(.N_BANK(N_BANK), .BANK_W(BANK_W)) i_dec (
    .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .open_vec(open_vec), .act_rdy_vec(act_rdy_vec),
    .rw_rdy_vec(rw_rdy_vec), .pre_rdy_vec(pre_rdy_vec),
    .grant(grant), .illegal(illegal),
    .act_go(act_go), .close_go(close_go), .prea_go(prea_go)
  );
endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk
  import ddr2_guard_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int CNT_W  = 6,
  parameter int LAT_W  = 4,
  localparam int BANK_W = $clog2(N_BANK)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [CMD_W-1:0]  req_cmd,
  input logic [BANK_W-1:0] req_bank,
  input logic              grant,
  input logic              illegal,
  input logic [N_BANK-1:0] open_vec,
  input logic [CNT_W-1:0]  trcd_q,
  input logic [CNT_W-1:0]  tras_q,
  input logic [LAT_W-1:0]  rd_lat,
  input logic [LAT_W-1:0]  wr_lat
);
  // cycles since each bank's last granted ACTIVATE, saturating
  logic [CNT_W:0] since_act [N_BANK];

  always_ff @(posedge clk) begin
    for (int b = 0; b < N_BANK; b++) begin
      if (rst)
        since_act[b] <= '1;
      else if (grant && req_cmd == CMD_ACT && req_bank == BANK_W'(b))
        since_act[b] <= (CNT_W+1)'(1);
      else if (since_act[b] != '1)
        since_act[b] <= since_act[b] + (CNT_W+1)'(1);
    end
  end

  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    grant |-> req_valid);

  assert_grant_not_illegal_R9: assert property (@(posedge clk) disable iff (rst)
    !(grant && illegal));

  assert_rw_needs_open_R6: assert property (@(posedge clk) disable iff (rst)
    (grant && (req_cmd == CMD_RD || req_cmd == CMD_WR)) |-> open_vec[req_bank]);

  assert_act_needs_closed_R6: assert property (@(posedge clk) disable iff (rst)
    (grant && req_cmd == CMD_ACT) |-> !open_vec[req_bank]);

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (rst)
    (grant && req_cmd == CMD_ACT) |=> open_vec[$past(req_bank)]);

  assert_rcd_window_R2: assert property (@(posedge clk) disable iff (rst)
    (grant && (req_cmd == CMD_RD || req_cmd == CMD_WR))
      |-> (since_act[req_bank] >= {1'b0, trcd_q}));

  assert_ras_window_R3: assert property (@(posedge clk) disable iff (rst)
    (grant && req_cmd == CMD_PRE && open_vec[req_bank])
      |-> (since_act[req_bank] >= {1'b0, tras_q}));

  assert_wr_lat_offset_R7: assert property (@(posedge clk) disable iff (rst)
    wr_lat == rd_lat - LAT_W'(1));
endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(
  .N_BANK(N_BANK), .CNT_W(CNT_W), .LAT_W(LAT_W)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_bank(req_bank), .grant(grant), .illegal(illegal),
  .open_vec(open_vec), .trcd_q(t_rcd), .tras_q(t_ras),
  .rd_lat(rd_lat), .wr_lat(wr_lat)
);

// File: tb/test_ddr2_bank_guard.sv
`timescale 1ns/1ps
module test_ddr2_bank_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [2:0] req_bank = 3'd0;
  logic       grant, illegal;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_trcd = '0, cfg_trp = '0, cfg_tras = '0, cfg_trc = '0, cfg_tprea = '0;
  logic [2:0] cfg_cl = '0, cfg_al = '0;
  logic [3:0] rd_lat, wr_lat;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, PREA = 3'd5;

  always #2.5 clk = ~clk;

  ddr2_bank_guard i_ddr2_bank_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .grant(grant), .illegal(illegal),
    .cfg_we(cfg_we), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_trc(cfg_trc), .cfg_tprea(cfg_tprea),
    .cfg_cl(cfg_cl), .cfg_al(cfg_al), .rd_lat(rd_lat), .wr_lat(wr_lat)
  );

  typedef struct {
    int    exp_delay;  // cycles after previous grant, -1 = not checked
    bit    exp_ill;
    string tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0, n_fail = 0;
  int    cyc = 0, last_g = 0;
  bit    done = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the expected outcome when the design answers
  always @(negedge clk) begin : mon
    item_t it;
    #1;
    if (req_valid && (grant || illegal) && !done) begin
      chk(!(grant && illegal), "R9 grant with illegal", int'(grant & illegal), 0);
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", 1, 0);
      end else begin
        it = sb_q.pop_front();
        chk(illegal == it.exp_ill, {it.tag, " illegal flag"}, int'(illegal), int'(it.exp_ill));
        if (grant && it.exp_delay >= 0)
          chk(cyc - last_g == it.exp_delay, {it.tag, " grant delay"}, cyc - last_g, it.exp_delay);
      end
      if (grant) last_g = cyc;
      done = 1'b1;
    end
  end

  // driver: called at a negedge, returns at a negedge with the request dropped
  task automatic issue(input logic [2:0] c, input logic [2:0] b,
                       input int dly, input bit ill, input string tag);
    item_t it;
    it.exp_delay = dly;
    it.exp_ill   = ill;
    it.tag       = tag;
    sb_q.push_back(it);
    done      = 1'b0;
    req_cmd   = c;
    req_bank  = b;
    req_valid = 1'b1;
    wait (done);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input int trcd, input int trp, input int tras,
                           input int trc, input int tprea, input int cl,
                           input int al, input int exp_rd, input string tag);
    cfg_trcd = 6'(trcd); cfg_trp = 6'(trp); cfg_tras = 6'(tras);
    cfg_trc = 6'(trc); cfg_tprea = 6'(tprea);
    cfg_cl = 3'(cl); cfg_al = 3'(al);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(rd_lat == 4'(exp_rd), {tag, " rd_lat"}, int'(rd_lat), exp_rd);
    chk(wr_lat == 4'(exp_rd - 1), "R7 wr_lat one below rd_lat", int'(wr_lat), exp_rd - 1);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    chk(rd_lat == 4'd5, "R10 reset rd_lat", int'(rd_lat), 5);
    chk(wr_lat == 4'd4, "R10 reset wr_lat", int'(wr_lat), 4);
    chk(!grant && !illegal, "R10 idle outputs", int'(grant | illegal), 0);
    @(negedge clk);

    // R6: NOP raises nothing
    req_cmd = NOP; req_bank = 3'd0; req_valid = 1'b1;
    #1;
    chk(!grant && !illegal, "R6 NOP", int'({grant, illegal}), 0);
    @(negedge clk);
    req_valid = 1'b0;

    issue(RD,  3'd2, -1, 1'b1, "R6 read to closed bank");
    issue(WR,  3'd4, -1, 1'b1, "R6 write to closed bank");
    issue(PRE, 3'd3, -1, 1'b0, "R11 precharge closed bank");
    issue(ACT, 3'd3,  1, 1'b0, "R11 no precharge wait after no-op");
    issue(ACT, 3'd0,  1, 1'b0, "R1 activate other bank");
    issue(ACT, 3'd0, -1, 1'b1, "R6 activate open bank");
    issue(RD,  3'd0,  5, 1'b0, "R2 read after tRCD");
    issue(WR,  3'd3,  1, 1'b0, "R2 write to rested bank");
    issue(PRE, 3'd0, 12, 1'b0, "R3 precharge after tRAS");
    issue(ACT, 3'd0,  5, 1'b0, "R4 activate after tRP");
    issue(PREA, 3'd0, 18, 1'b0, "R5 precharge-all waits tRAS");
    issue(ACT, 3'd5,  7, 1'b0, "R5 activate after tPREA");
    issue(PRE, 3'd5, 18, 1'b0, "R3 precharge bank5");

    // R8: accepted write, new latencies and timings
    cfg_write(3, 2, 6, 12, 4, 4, 2, 6, "R8 accepted config");
    issue(ACT, 3'd1, -1, 1'b0, "R8 activate under new timing");
    issue(WR,  3'd1,  3, 1'b0, "R8 R2 write after new tRCD");
    issue(PRE, 3'd1,  3, 1'b0, "R8 R3 precharge after new tRAS");
    issue(ACT, 3'd1,  6, 1'b0, "R4 activate held by tRC");
    cfg_write(3, 2, 6, 12, 4, 7, 0, 6, "R8 rejected while bank open");
    issue(PRE, 3'd1, -1, 1'b0, "R3 close bank1");
    cfg_write(3, 2, 6, 12, 4, 2, 0, 6, "R8 rejected CAS latency 2");
    cfg_write(3, 2, 6, 12, 4, 5, 7, 6, "R8 rejected additive latency 7");
    issue(3'd6, 3'd0, -1, 1'b1, "R6 unused code 6");
    issue(3'd7, 3'd2, -1, 1'b1, "R6 unused code 7");
    issue(PREA, 3'd0, -1, 1'b0, "R5 precharge-all with banks closed");
    issue(ACT, 3'd2,  4, 1'b0, "R5 R8 activate after new tPREA");

    #1;
    chk(!grant, "R9 no grant without request", int'(grant), 0);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule